// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

A bank of independent timer channels sits behind a word-addressed register bus. Each channel holds a control word, a reload value and a live counter. Once started, a channel counts one step per clock. It counts up toward all-ones or down toward zero, depending on a direction bit. When it reaches that terminal value it raises a sticky expiry flag. It then either reloads and keeps running, or parks on the terminal value.

Software starts a channel by writing its load value and then writing the control word with the enable bit set. It polls or clears the flag through the same control word. All channels share one level-sensitive interrupt line. That line is high while any channel has both its flag and its interrupt-enable bit set. Reads are combinational. Writes take effect at the clock edge that captures them.

Top module: `interval_timer_bank`

## Requirements
- R1: The channel index is the word address shifted right by two. The low two address bits pick the register: 0 is control, 1 is load value, 2 is live count and 3 is unmapped.
- R2: Control bits 0 to 10 are stored and read back as written, except bit 8 (flag), which a write never sets. Bits 11 to 31 read as zero.
- R3: A control write with bit 7 (enable) set copies the load value into the counter and starts counting. The count read in the cycle after that write equals the load value.
- R4: With bit 1 set (down), a running counter decrements once per clock. At the edge after it reads zero it expires and sets the flag (control bit 8).
- R5: With bit 1 clear (up), a running counter increments once per clock. At the edge after it reads all-ones it expires.
- R6: When bit 4 (auto-reload) is set, expiry loads the counter from the load value and counting continues.
- R7: When auto-reload is clear, the counter stays at the terminal value after expiry until the next control write with enable set.
- R8: A control write with enable clear freezes the counter at its current value. A control write does not advance the counter in that cycle.
- R9: Writing 1 to control bit 8 clears the flag, and writing 0 there leaves it unchanged. When an expiry and a clear fall in the same cycle, the flag stays set.
- R10: irq_o is high exactly when some channel has its flag set and control bit 6 (interrupt enable) set. It lags that condition by IRQ_REG cycles (default one).
- R11: Word 3 of any channel, and any channel index of NUM_CH or above, reads as zero. Writes there change no register.
- R12: Reset clears every control word, flag, load value and counter, and drives irq_o low.
- R13: Writes to the live count word are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data |
| irq_o | output | 1 | Shared level interrupt |

## Verification
Assertions check the per-cycle counter arithmetic on every cycle: single steps up or down, reload on expiry, parking on the terminal value, and freezing when stopped. On every cycle they also check that the flag rises only on an expiry, that the interrupt falls only after a bus write, and that unmapped reads return zero. The bench scenarios show what needs whole sequences. These are the exact expiry cycle measured from the start write, read-back masking of the control word, and write-one-to-clear against write-zero. They also cover address aliasing between channels, ignored writes, and interrupt gating by the enable bit.

// File: rtl/itb_pkg.sv
package itb_pkg;
   localparam int CB_MODE   = 0;
   localparam int CB_DOWN   = 1;
   localparam int CB_GEN    = 2;
   localparam int CB_CAPT   = 3;
   localparam int CB_RELOAD = 4;
   localparam int CB_LOADB  = 5;
   localparam int CB_IE     = 6;
   localparam int CB_EN     = 7;
   localparam int CB_FLAG   = 8;
   localparam int CB_PWM    = 9;
   localparam int CB_ALL    = 10;
   localparam int CTRL_BITS = 11;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_LOAD  = 2'd1,
      SEL_COUNT = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/itb_decode.sv
module itb_decode
   import itb_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8,
   localparam int IDX_W = ADDR_W - 2
) (
   input  logic              sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_CH-1:0] ch_match_o,
   output reg_sel_e          rsel_o,
   output logic              in_range_o
);
   logic [IDX_W-1:0] idx;

   assign idx        = addr_i[ADDR_W-1:2];
   assign rsel_o     = reg_sel_e'(addr_i[1:0]);
   assign in_range_o = ({1'b0, idx} < (IDX_W+1)'(NUM_CH)) && (rsel_o != SEL_NONE);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_match
      assign ch_match_o[i] = sel_i && in_range_o && (idx == IDX_W'(i));
   end
endmodule

// File: rtl/itb_channel.sv
module itb_channel
   import itb_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl_i,
   input  logic             wr_load_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] ctrl_word_o,
   output logic [CNT_W-1:0] load_o,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_req_o
);
   logic [CTRL_BITS-1:0] ctrl_q;
   logic                 flag_q;
   logic                 run_q;
   logic [CNT_W-1:0]     load_q;
   logic [CNT_W-1:0]     cnt_q;
   logic                 step;
   logic                 at_term;
   logic                 hit;
   logic                 down;

   assign down    = ctrl_q[CB_DOWN];
   assign step    = run_q && ctrl_q[CB_EN];
   assign at_term = down ? (cnt_q == '0) : (cnt_q == '1);
   assign hit     = step && at_term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         run_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (wr_ctrl_i) begin
         ctrl_q          <= wdata_i[CTRL_BITS-1:0];
         ctrl_q[CB_FLAG] <= 1'b0;
         if (wdata_i[CB_EN]) begin
            cnt_q <= load_q;
            run_q <= 1'b1;
         end else begin
            run_q <= 1'b0;
         end
      end else if (step) begin
         if (at_term) begin
            if (ctrl_q[CB_RELOAD]) cnt_q <= load_q;
            else                   run_q <= 1'b0;
         end else if (down) begin
            cnt_q <= cnt_q - 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         load_q <= '0;
      else if (wr_load_i) load_q <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                               flag_q <= 1'b0;
      else if (hit)                             flag_q <= 1'b1;
      else if (wr_ctrl_i && wdata_i[CB_FLAG])   flag_q <= 1'b0;
   end

   always_comb begin
      ctrl_word_o                  = '0;
      ctrl_word_o[CTRL_BITS-1:0]   = ctrl_q;
      ctrl_word_o[CB_FLAG]         = flag_q;
   end

   assign load_o    = load_q;
   assign count_o   = cnt_q;
   assign irq_req_o = flag_q && ctrl_q[CB_IE];

   AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step && down && !at_term && !wr_ctrl_i |=> cnt_q == $past(cnt_q) - 1'b1); // R4
   AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step && !down && !at_term && !wr_ctrl_i |=> cnt_q == $past(cnt_q) + 1'b1); // R5
   AST_RELOAD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit && ctrl_q[CB_RELOAD] && !wr_ctrl_i |=> cnt_q == $past(load_q)); // R6
   AST_PARK_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !ctrl_q[CB_RELOAD] && !wr_ctrl_i |=> $stable(cnt_q) && !step); // R7
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !wr_ctrl_i |=> $stable(cnt_q)); // R8
   AST_FLAG_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_q |=> !flag_q || $past(hit)); // R9
endmodule

// File: rtl/itb_irq_merge.sv
module itb_irq_merge #(
   parameter int NUM_CH  = 4,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_i,
   output logic              irq_o
);
   logic any_req;

   assign any_req = |req_i;

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_req;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      assign irq_o = rst_n && any_req;
   end
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
   import itb_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int ADDR_W  = 8,
   parameter int CNT_W   = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq_o
);
   localparam int IDX_W    = ADDR_W - 2;
   localparam int IRQ_LAG  = IRQ_REG ? 2 : 1;

   if (NUM_CH < 1) begin : g_chk_n
      $error("NUM_CH must be at least 1");
   end
   if (CNT_W < CTRL_BITS) begin : g_chk_w
      $error("CNT_W too narrow for the control word");
   end
   if (ADDR_W < 3 || NUM_CH > (1 << IDX_W)) begin : g_chk_a
      $error("ADDR_W cannot address NUM_CH channels");
   end

   logic [NUM_CH-1:0] ch_match;
   reg_sel_e          rsel;
   logic              in_range;
   logic [NUM_CH-1:0] irq_req;
   logic [CNT_W-1:0]  ch_ctrl  [NUM_CH];
   logic [CNT_W-1:0]  ch_load  [NUM_CH];
   logic [CNT_W-1:0]  ch_count [NUM_CH];

   itb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
      .sel_i      (bus_sel),
      .addr_i     (bus_addr),
      .ch_match_o (ch_match),
      .rsel_o     (rsel),
      .in_range_o (in_range)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      itb_channel #(.CNT_W(CNT_W)) u_ch (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_ctrl_i   (ch_match[i] && bus_we && (rsel == SEL_CTRL)),
         .wr_load_i   (ch_match[i] && bus_we && (rsel == SEL_LOAD)),
         .wdata_i     (bus_wdata),
         .ctrl_word_o (ch_ctrl[i]),
         .load_o      (ch_load[i]),
         .count_o     (ch_count[i]),
         .irq_req_o   (irq_req[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_match[i]) begin
            case (rsel)
               SEL_CTRL:  bus_rdata = ch_ctrl[i];
               SEL_LOAD:  bus_rdata = ch_load[i];
               SEL_COUNT: bus_rdata = ch_count[i];
               default:   bus_rdata = '0;
            endcase
         end
      end
   end

   itb_irq_merge #(.NUM_CH(NUM_CH), .IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (irq_req),
      .irq_o (irq_o)
   );

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && !in_range |-> bus_rdata == '0); // R11
   AST_IRQ_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(bus_sel && bus_we, IRQ_LAG)); // R10
   AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_match)); // R1
endmodule

// File: tb/interval_timer_bank_tb.sv
`timescale 1ns/1ps
module interval_timer_bank_tb;
   localparam int  NUM_CH = 4;
   localparam int  ADDR_W = 8;
   localparam int  CNT_W  = 32;
   localparam time CLK_P  = 20ns;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_sel;
   logic              bus_we;
   logic [ADDR_W-1:0] bus_addr;
   logic [CNT_W-1:0]  bus_wdata;
   logic [CNT_W-1:0]  bus_rdata;
   logic              irq_o;

   typedef struct {
      logic [CNT_W-1:0] exp;
      string            tag;
   } item_t;
   item_t sb[$];

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #(CLK_P/2) clk = ~clk;

   interval_timer_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic chk(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per read cycle
   always @(negedge clk) begin
      if (!done && rst_n === 1'b1 && bus_sel === 1'b1 && bus_we === 1'b0) begin
         if (sb.size() == 0) begin
            chk("scoreboard-underflow", bus_rdata, 'x);
         end else begin
            item_t it;
            it = sb.pop_front();
            chk(it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic wr(input int addr, input logic [CNT_W-1:0] data);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
   endtask

   task automatic rd(input int addr, input logic [CNT_W-1:0] exp, input string tag);
      item_t it;
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr); bus_wdata = '0;
      it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         bus_sel = 1'b0; bus_we = 1'b0;
      end
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk);
      chk(tag, {{(CNT_W-1){1'b0}}, irq_o}, {{(CNT_W-1){1'b0}}, exp});
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(posedge clk);
      chk_irq(1'b0, "R12 irq in reset");
      @(posedge clk); #1; rst_n = 1'b1;

      // R12 reset state
      rd(0, 32'h0, "R12 ch0 ctrl");
      rd(2, 32'h0, "R12 ch0 count");
      rd(9, 32'h0, "R12 ch2 load");

      // R2 control masking: ch1 ctrl, enable off, flag bit written
      wr(4, 32'hFFFF_FF7F);
      rd(4, 32'h0000_067F, "R2 ctrl readback");

      // R1/R3/R4 down count on ch0, load 5, en|down|ie
      wr(1, 32'd5);
      wr(0, 32'h0000_00C2);
      rd(2, 32'd5, "R3 count equals load");
      rd(2, 32'd4, "R4 step 4");
      rd(2, 32'd3, "R4 step 3");
      rd(2, 32'd2, "R4 step 2");
      rd(2, 32'd1, "R4 step 1");
      rd(2, 32'd0, "R4 reaches zero");
      rd(0, 32'h0000_01C2, "R4 flag set at expiry");
      idle(3);
      rd(2, 32'd0, "R7 parked at zero");
      idle(1);
      chk_irq(1'b1, "R10 irq with flag and ie");

      // R9 write zero keeps flag, write one clears it
      wr(0, 32'h0000_0042);
      rd(0, 32'h0000_0142, "R9 write zero preserves flag");
      wr(0, 32'h0000_0142);
      rd(0, 32'h0000_0042, "R9 write one clears flag");
      idle(2);
      chk_irq(1'b0, "R10 irq falls after clear");

      // R5/R6 up count with auto-reload on ch2 (no ie)
      wr(9, 32'hFFFF_FFFD);
      wr(8, 32'h0000_0090);
      rd(10, 32'hFFFF_FFFD, "R5 start");
      rd(10, 32'hFFFF_FFFE, "R5 step");
      rd(10, 32'hFFFF_FFFF, "R5 all-ones");
      rd(10, 32'hFFFF_FFFD, "R6 reloaded");
      rd(8,  32'h0000_0190, "R6 flag set, still enabled");
      idle(2);
      chk_irq(1'b0, "R10 flag without ie");

      // R8 freeze on ch3, then R13 ignored write, then R3 re-enable
      wr(13, 32'd100);
      wr(12, 32'h0000_0082);
      rd(14, 32'd100, "R3 ch3 start");
      wr(12, 32'h0000_0002);
      rd(14, 32'd99, "R8 frozen");
      idle(5);
      rd(14, 32'd99, "R8 still frozen");
      wr(14, 32'h0000_1234);
      rd(14, 32'd99, "R13 count write ignored");
      wr(12, 32'h0000_0082);
      rd(14, 32'd100, "R3 re-enable reloads");
      wr(12, 32'h0000_0002);

      // R11 unmapped word and channel
      wr(3, 32'h0000_FFFF);
      rd(3, 32'h0, "R11 word3 reads zero");
      wr(16, 32'h0000_AAAA);
      wr(17, 32'h0000_BBBB);
      rd(16, 32'h0, "R11 ch4 ctrl zero");
      rd(17, 32'h0, "R11 ch4 load zero");
      rd(1, 32'd5, "R11 ch0 load untouched");
      rd(0, 32'h0000_0042, "R11 ch0 ctrl untouched");

      // R1 channel separation
      wr(5, 32'd7);
      rd(5, 32'd7, "R1 ch1 load");
      rd(1, 32'd5, "R1 ch0 load distinct");

      // R12 reset mid-run
      idle(1);
      @(posedge clk); #1; rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1; rst_n = 1'b1;
      rd(8,  32'h0, "R12 ch2 ctrl cleared");
      rd(10, 32'h0, "R12 ch2 count cleared");
      idle(1);
      chk_irq(1'b0, "R12 irq low");

      idle(2);
      if (sb.size() != 0) chk("R1 scoreboard drained", 32'(sb.size()), 32'h0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule